// File: doc/BRIEF.md
# Host-to-Core Mailbox Unit

The mailbox carries signalling between a remote host on the PCI side and a local processor core. Each side has a simple register port with an address, write data, a write enable, a read enable and read data. The host rings the core through a 32-bit inbound doorbell and a bank of 32-bit inbound message registers. The core rings the host through a 32-bit outbound doorbell and a matching bank of outbound message registers. Every message register and each doorbell is an interrupt source with a pending status bit and a mask bit. The core-facing sources drive an active-high core interrupt. The host-facing sources share one active-low host interrupt line.

Both register ports are plain control ports and have no back-pressure. A write is taken on every clock edge where its write enable is high. A read is taken on every clock edge where its read enable is high. Read data is registered: it appears one edge after the read is accepted and holds until the next accepted read.

Word map, identical on both ports: 0 = inbound doorbell, 1 = outbound doorbell, 2 = control word, 4+i = inbound message i, 8+i = outbound message i. In the control word, bit 0 shows the doorbell summary and bit 1+i shows message i pending; these bits are read-only. Mask bits sit at 8+k, where source k uses the same numbering as the status bits. Each port's control word covers that port's own interrupt sources: inbound for the core, outbound for the host.

Top module: `mbox_unit`

## Requirements
- R1: A host write to word 0 ORs the written ones into the inbound doorbell. Bits written as zero keep their value.
- R2: A core write to word 0 clears the inbound doorbell bits written as one, and a write of zero changes nothing. The core interrupt is high while any inbound doorbell bit is set and control bit 8 is clear.
- R3: A core write to word 1 ORs its ones into the outbound doorbell. The host line is low while any outbound doorbell bit is set and host control bit 8 is clear.
- R4: A host write to word 1 clears the outbound doorbell bits written as one. The host line stays low until every bit is cleared.
- R5: If the core sets and the host clears the same outbound doorbell bit on the same edge, the bit ends up set.
- R6: A host write to word 4+i stores the data, sets core status bit 1+i and raises the core interrupt. The core reads the data at word 4+i and clears the status by writing one to control bit 1+i.
- R7: A core write to word 8+i stores the data, sets host status bit 1+i and pulls the host line low. A host read of word 8+i returns the data and clears that status.
- R8: A masked source still sets its status bit but does not drive its interrupt. Clearing the mask lets the pending status drive the interrupt.
- R9: After reset all registers, statuses and masks are zero, the core interrupt is low, the host line is high and read data is zero.
- R10: Read data changes only on the edge after an accepted read and holds while the read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 4 | Host port word address |
| h_wdata | input | 32 | Host write data |
| h_we | input | 1 | Host write enable |
| h_re | input | 1 | Host read enable |
| h_rdata | output | 32 | Host registered read data |
| c_addr | input | 4 | Core port word address |
| c_wdata | input | 32 | Core write data |
| c_we | input | 1 | Core write enable |
| c_re | input | 1 | Core read enable |
| c_rdata | output | 32 | Core registered read data |
| core_irq | output | 1 | Interrupt to the local core, active high |
| host_irq_n | output | 1 | Interrupt to the host, active low |

## Verification
The bench clears only some of the outbound doorbell bits and checks that the host line stays low. A design that released the line on any clear would fail there. It writes zero to the inbound doorbell, which a design treating the write as a plain store would wipe. It drives a core set and a host clear into the same outbound bit on one edge. A design where the clear wins would drop the host's notice. It also rings sources while they are masked and checks that the status still records the event and that the interrupt fires once the mask is lifted. A design that gated the status instead of the output would lose those events. Finally, it checks that a host read of an outbound message clears only that message's status, and that read data holds between reads.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int OFF_IDB     = 0;
  localparam int OFF_ODB     = 1;
  localparam int OFF_CTRL    = 2;
  localparam int OFF_IMSG    = 4;
  localparam int OFF_OMSG    = 8;
  localparam int MASK_LSB    = 8;
  localparam int MAX_MSG     = 4;

  typedef enum logic [0:0] {SIDE_HOST = 1'b0, SIDE_CORE = 1'b1} side_e;
endpackage

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] bits_o,
  output logic         any_o
);
  logic [W-1:0] bits_q;

  // set dominates a clear of the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= (bits_q & ~clr_i) | set_i;
  end

  assign bits_o = bits_q;
  assign any_o  = |bits_q;

  a_r5_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((bits_q & $past(set_i)) == $past(set_i)));

  a_r1_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0) |=> ((bits_q & ~$past(bits_q)) == '0));
endmodule

// File: rtl/mbox_msg_slot.sv
module mbox_msg_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  output logic [W-1:0] data_o,
  output logic         pend_o
);
  logic [W-1:0] data_q;
  logic         pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_i) data_q <= wdata_i;
      if (wr_i)       pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign pend_o = pend_q;

  a_r6_write_pends: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (pend_q && data_q == $past(wdata_i)));

  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !wr_i) |=> !pend_q);
endmodule

// File: rtl/mbox_side.sv
// Status, mask and register read-back for one port of the mailbox.
module mbox_side #(
  parameter int W     = 32,
  parameter int AW    = 4,
  parameter int NS    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [NS-1:0] stat_i,
  input  logic [W-1:0]  idb_i,
  input  logic [W-1:0]  odb_i,
  input  logic [W-1:0]  imsg_i [NS-1],
  input  logic [W-1:0]  omsg_i [NS-1],
  output logic [NS-1:0] mask_o,
  output logic          irq_o,
  output logic [W-1:0]  rdata_o
);
  import mbox_pkg::*;

  localparam logic [AW-1:0] A_IDB  = AW'(OFF_IDB);
  localparam logic [AW-1:0] A_ODB  = AW'(OFF_ODB);
  localparam logic [AW-1:0] A_CTRL = AW'(OFF_CTRL);

  logic [NS-1:0] mask_q;
  logic [W-1:0]  rd_mux;
  logic [W-1:0]  rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       mask_q <= '0;
    else if (we_i && addr_i == A_CTRL) mask_q <= wdata_i[MASK_LSB +: NS];
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_IDB)  rd_mux = idb_i;
    if (addr_i == A_ODB)  rd_mux = odb_i;
    if (addr_i == A_CTRL) begin
      rd_mux[0 +: NS]        = stat_i;
      rd_mux[MASK_LSB +: NS] = mask_q;
    end
    for (int i = 0; i < NS - 1; i++) begin
      if (addr_i == AW'(OFF_IMSG + i)) rd_mux = imsg_i[i];
      if (addr_i == AW'(OFF_OMSG + i)) rd_mux = omsg_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign mask_o  = mask_q;
  assign irq_o   = |(stat_i & ~mask_q);
  assign rdata_o = rdata_q;

  a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !re_i |=> $stable(rdata_q));
endmodule

// File: rtl/mbox_unit.sv
module mbox_unit #(
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int N_MSG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  input  logic          h_we,
  input  logic          h_re,
  output logic [DW-1:0] h_rdata,
  input  logic [AW-1:0] c_addr,
  input  logic [DW-1:0] c_wdata,
  input  logic          c_we,
  input  logic          c_re,
  output logic [DW-1:0] c_rdata,
  output logic          core_irq,
  output logic          host_irq_n
);
  import mbox_pkg::*;

  localparam int NS = N_MSG + 1;
  localparam logic [AW-1:0] A_IDB  = AW'(OFF_IDB);
  localparam logic [AW-1:0] A_ODB  = AW'(OFF_ODB);
  localparam logic [AW-1:0] A_CTRL = AW'(OFF_CTRL);

  initial begin
    if (N_MSG < 1 || N_MSG > MAX_MSG) $error("N_MSG out of range");
  end

  // doorbells
  logic [DW-1:0] idb_set, idb_clr, idb_bits;
  logic [DW-1:0] odb_set, odb_clr, odb_bits;
  logic          idb_any, odb_any;

  assign idb_set = (h_we && h_addr == A_IDB) ? h_wdata : '0;
  assign idb_clr = (c_we && c_addr == A_IDB) ? c_wdata : '0;
  assign odb_set = (c_we && c_addr == A_ODB) ? c_wdata : '0;
  assign odb_clr = (h_we && h_addr == A_ODB) ? h_wdata : '0;

  mbox_doorbell #(.W(DW)) u_idb (
    .clk(clk), .rst_n(rst_n), .set_i(idb_set), .clr_i(idb_clr),
    .bits_o(idb_bits), .any_o(idb_any));

  mbox_doorbell #(.W(DW)) u_odb (
    .clk(clk), .rst_n(rst_n), .set_i(odb_set), .clr_i(odb_clr),
    .bits_o(odb_bits), .any_o(odb_any));

  // message registers
  logic [DW-1:0]    imsg_data [N_MSG];
  logic [DW-1:0]    omsg_data [N_MSG];
  logic [N_MSG-1:0] imsg_pend, omsg_pend;

  for (genvar i = 0; i < N_MSG; i++) begin : g_msg
    localparam logic [AW-1:0] A_IM = AW'(OFF_IMSG + i);
    localparam logic [AW-1:0] A_OM = AW'(OFF_OMSG + i);
    logic im_wr, im_clr, om_wr, om_clr;

    assign im_wr  = h_we && h_addr == A_IM;
    assign im_clr = c_we && c_addr == A_CTRL && c_wdata[1 + i];
    assign om_wr  = c_we && c_addr == A_OM;
    assign om_clr = h_re && h_addr == A_OM;

    mbox_msg_slot #(.W(DW)) u_in (
      .clk(clk), .rst_n(rst_n), .wr_i(im_wr), .wdata_i(h_wdata),
      .clr_i(im_clr), .data_o(imsg_data[i]), .pend_o(imsg_pend[i]));

    mbox_msg_slot #(.W(DW)) u_out (
      .clk(clk), .rst_n(rst_n), .wr_i(om_wr), .wdata_i(c_wdata),
      .clr_i(om_clr), .data_o(omsg_data[i]), .pend_o(omsg_pend[i]));
  end

  // per-port status, mask and read-back
  logic [NS-1:0] core_stat, host_stat, core_mask, host_mask;
  logic          core_irq_w, host_irq_w;

  assign core_stat = {imsg_pend, idb_any};
  assign host_stat = {omsg_pend, odb_any};

  mbox_side #(.W(DW), .AW(AW), .NS(NS)) u_core_side (
    .clk(clk), .rst_n(rst_n), .addr_i(c_addr), .wdata_i(c_wdata),
    .we_i(c_we), .re_i(c_re), .stat_i(core_stat),
    .idb_i(idb_bits), .odb_i(odb_bits), .imsg_i(imsg_data), .omsg_i(omsg_data),
    .mask_o(core_mask), .irq_o(core_irq_w), .rdata_o(c_rdata));

  mbox_side #(.W(DW), .AW(AW), .NS(NS)) u_host_side (
    .clk(clk), .rst_n(rst_n), .addr_i(h_addr), .wdata_i(h_wdata),
    .we_i(h_we), .re_i(h_re), .stat_i(host_stat),
    .idb_i(idb_bits), .odb_i(odb_bits), .imsg_i(imsg_data), .omsg_i(omsg_data),
    .mask_o(host_mask), .irq_o(host_irq_w), .rdata_o(h_rdata));

  assign core_irq   = core_irq_w;
  assign host_irq_n = ~host_irq_w;

  a_r2_core_rings: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && h_addr == A_IDB && h_wdata != '0 && !core_mask[0] &&
     !(c_we && c_addr == A_CTRL)) |=> core_irq);

  a_r3_host_rings: assert property (@(posedge clk) disable iff (!rst_n)
    (c_we && c_addr == A_ODB && c_wdata != '0 && !host_mask[0] &&
     !(h_we && h_addr == A_CTRL)) |=> !host_irq_n);

  a_r4_line_held: assert property (@(posedge clk) disable iff (!rst_n)
    (odb_any && !host_mask[0] && (odb_bits & ~odb_clr) != '0 &&
     !(h_we && h_addr == A_CTRL)) |=> !host_irq_n);

  a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!idb_any && imsg_pend == '0) |-> !core_irq);
endmodule

// File: tb/tb_mbox_unit.sv
module tb_mbox_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] W_IDB = 4'd0, W_ODB = 4'd1, W_CTRL = 4'd2;
  localparam logic [3:0] W_IM0 = 4'd4, W_IM1 = 4'd5, W_OM0 = 4'd8, W_OM1 = 4'd9;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  h_addr = '0, c_addr = '0;
  logic [31:0] h_wdata = '0, c_wdata = '0, h_rdata, c_rdata;
  logic        h_we = 1'b0, h_re = 1'b0, c_we = 1'b0, c_re = 1'b0;
  logic        core_irq, host_irq_n;
  int checks = 0, fails = 0, cyc = 0;

  mbox_unit dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hw(logic [3:0] a, logic [31:0] d);
    h_addr = a; h_wdata = d; h_we = 1'b1;
    @(negedge clk); h_we = 1'b0;
  endtask
  task automatic cw(logic [3:0] a, logic [31:0] d);
    c_addr = a; c_wdata = d; c_we = 1'b1;
    @(negedge clk); c_we = 1'b0;
  endtask
  task automatic hr(logic [3:0] a, output logic [31:0] d);
    h_addr = a; h_re = 1'b1;
    @(negedge clk); h_re = 1'b0; d = h_rdata;
  endtask
  task automatic cr(logic [3:0] a, output logic [31:0] d);
    c_addr = a; c_re = 1'b1;
    @(negedge clk); c_re = 1'b0; d = c_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9 core_irq", 32'(core_irq), 0);
    chk("R9 host_irq_n", 32'(host_irq_n), 1);
    chk("R9 h_rdata", h_rdata, 0);
    cr(W_CTRL, d); chk("R9 core ctrl", d, 0);
    hr(W_ODB, d);  chk("R9 odb", d, 0);
  endtask

  task automatic t_inbound_db();
    logic [31:0] d;
    hw(W_IDB, 32'h0000_00A5);
    cr(W_IDB, d); chk("R1 idb set", d, 32'hA5);
    chk("R2 core_irq on", 32'(core_irq), 1);
    hw(W_IDB, 32'h0000_0100);
    cr(W_IDB, d); chk("R1 idb or", d, 32'h1A5);
    cw(W_IDB, 32'h5);
    cr(W_IDB, d); chk("R2 w1c partial", d, 32'h1A0);
    cw(W_IDB, 32'h0);
    cr(W_IDB, d); chk("R2 zero write", d, 32'h1A0);
    chk("R2 irq held", 32'(core_irq), 1);
    cw(W_IDB, 32'h1A0);
    chk("R2 core_irq off", 32'(core_irq), 0);
  endtask

  task automatic t_outbound_db();
    logic [31:0] d;
    cw(W_ODB, 32'hF0);
    chk("R3 host line low", 32'(host_irq_n), 0);
    hr(W_ODB, d); chk("R3 odb value", d, 32'hF0);
    hw(W_ODB, 32'h30);
    hr(W_ODB, d); chk("R4 partial clear", d, 32'hC0);
    chk("R4 line still low", 32'(host_irq_n), 0);
    hw(W_ODB, 32'hC0);
    chk("R4 line released", 32'(host_irq_n), 1);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    cw(W_ODB, 32'h1);
    c_addr = W_ODB; c_wdata = 32'h1; c_we = 1'b1;
    h_addr = W_ODB; h_wdata = 32'h1; h_we = 1'b1;
    @(negedge clk); c_we = 1'b0; h_we = 1'b0;
    hr(W_ODB, d); chk("R5 set wins", d, 32'h1);
    chk("R5 line low", 32'(host_irq_n), 0);
    hw(W_ODB, 32'h1);
    chk("R5 cleanup", 32'(host_irq_n), 1);
  endtask

  task automatic t_inbound_msg();
    logic [31:0] d;
    hw(W_IM0, 32'hDEAD_BEEF);
    chk("R6 irq msg0", 32'(core_irq), 1);
    cr(W_IM0, d); chk("R6 data0", d, 32'hDEAD_BEEF);
    cr(W_CTRL, d); chk("R6 status0", d, 32'h2);
    hw(W_IM1, 32'h0BAD_F00D);
    cw(W_CTRL, 32'h2);
    cr(W_CTRL, d); chk("R6 clear only 0", d, 32'h4);
    chk("R6 irq msg1", 32'(core_irq), 1);
    cr(W_IM1, d); chk("R6 data1", d, 32'h0BAD_F00D);
    cw(W_CTRL, 32'h4);
    chk("R6 irq off", 32'(core_irq), 0);
  endtask

  task automatic t_outbound_msg();
    logic [31:0] d;
    cw(W_OM1, 32'h1234_5678);
    chk("R7 line low", 32'(host_irq_n), 0);
    cw(W_OM0, 32'h0000_0042);
    hr(W_CTRL, d); chk("R7 status", d, 32'h6);
    hr(W_OM1, d); chk("R7 data1", d, 32'h1234_5678);
    hr(W_CTRL, d); chk("R7 read clears one", d, 32'h2);
    hr(W_OM0, d); chk("R7 data0", d, 32'h42);
    chk("R7 line released", 32'(host_irq_n), 1);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    cw(W_CTRL, 32'h100);
    hw(W_IDB, 32'h8);
    chk("R8 core masked", 32'(core_irq), 0);
    cr(W_CTRL, d); chk("R8 status kept", d, 32'h101);
    cw(W_CTRL, 32'h0);
    chk("R8 core unmasked", 32'(core_irq), 1);
    cw(W_IDB, 32'h8);
    hw(W_CTRL, 32'h200);
    cw(W_OM0, 32'h77);
    chk("R8 host masked", 32'(host_irq_n), 1);
    hw(W_CTRL, 32'h0);
    chk("R8 host unmasked", 32'(host_irq_n), 0);
    hr(W_OM0, d);
    chk("R8 cleanup", 32'(host_irq_n), 1);
  endtask

  task automatic t_rdlat();
    logic [31:0] d;
    hw(W_IM0, 32'hAAAA_5555);
    hr(W_IM0, d);
    hw(W_IM0, 32'h1111_2222);
    @(negedge clk);
    chk("R10 holds", h_rdata, 32'hAAAA_5555);
    h_addr = W_IM0; h_re = 1'b1;
    chk("R10 not before edge", h_rdata, 32'hAAAA_5555);
    @(negedge clk); h_re = 1'b0;
    chk("R10 after edge", h_rdata, 32'h1111_2222);
    cw(W_CTRL, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_inbound_db();
    t_outbound_db();
    t_collision();
    t_inbound_msg();
    t_outbound_msg();
    t_mask();
    t_rdlat();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule